// File: doc/BRIEF.md
# Peak-Current PWM Leg with Leading-Edge Blanking

This block is one switching leg of a peak-current-mode controller for a phase-shifted full bridge. An up-counting time base runs from zero to a programmed period and wraps. Two compare values set and clear two complementary-style drive outputs, A and B. The period and both compare values are written to shadow inputs. They take effect only when the counter restarts, so a control loop can update them at any time without corrupting the pulse in progress.

A comparator input goes high when the sensed current exceeds the peak reference. That input passes through a blanking filter, which ignores it for a programmable window early in each cycle, where switching noise would otherwise cause false trips. When a comparator high survives the filter and the trip logic is armed, three things happen on the same edge:

- output B is forced low;
- the trip latches;
- the counter is reloaded to phase zero.

The latched trip holds B low until a clear pulse. An external sync pulse from a master timer also reloads the counter to phase zero, but it does not trip.

The blanking filter is a state machine with states BL_DELAY, BL_MASK and BL_OPEN:

- Every counter restart moves it to BL_DELAY.
- It goes from BL_DELAY to BL_MASK after the offset has elapsed, or straight to BL_OPEN when the length is zero.
- It goes from BL_MASK to BL_OPEN after the length has elapsed.
- It stays in BL_OPEN until the next restart.

The trip logic has two states, TR_ARMED and TR_LATCHED. It moves from TR_ARMED to TR_LATCHED on an unblanked comparator high. It moves from TR_LATCHED back to TR_ARMED on a clear pulse.

Top module: `pcm_leg`

## Requirements
- R1: While reset is asserted and on the first cycle after release, the counter reads 0 and both outputs are low. Until the first restart, the working period is PRD_RST (100 by default), working compare A is PRD_RST+10, so A is never set, and working compare B is 20.
- R2: The counter increments by one per clock from 0 to period-1, then reads 0 on the next clock. The period must be at least 2.
- R3: The working period, compare A and compare B copy their shadow inputs only on the clock edge where the counter restarts (wrap or resync). A shadow change in mid-cycle does not alter the current cycle.
- R4: Output A is registered and changes one clock after the counter shows the triggering value. It is set when the counter equals compare A. It is cleared when the counter equals compare B, 0, or period-1.
- R5: Output B is registered in the same way. It is set when the counter equals compare B. It is cleared when the counter equals compare A, 0, or period-1.
- R6: Actions are prioritised in this order: counter zero and period-1 first, then the clearing compare match, then the setting compare match. For example, with compare A = 0 and compare B = period-1, both outputs stay low.
- R7: Let t be the number of clocks since the counter read 0. The blanking window covers blank_ofs ≤ t < blank_ofs+blank_len, with blank_ofs ≥ 1 and both values held constant. A comparator high inside the window causes neither a trip nor a resync.
- R8: An unblanked comparator high while armed causes three effects on that clock edge: B goes low, the trip latches, and the counter reloads to 0. A keeps its value on that edge unless a regular action applies to it.
- R9: While the trip is latched, B stays low and the comparator causes no further resync. A trip_clr pulse re-arms the trip, after which B sets again on its compare match.
- R10: sync_in high on a clock edge reloads the counter to 0. It does not trip and does not change either output on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prd_shadow | input | CW | Shadow period (counter runs 0..period-1) |
| cmpa_shadow | input | CW | Shadow compare A |
| cmpb_shadow | input | CW | Shadow compare B |
| blank_ofs | input | CW | Clocks from counter zero to the start of the blanking window |
| blank_len | input | CW | Length of the blanking window in clocks |
| cmp_hi | input | 1 | Comparator output, high when current exceeds the peak reference |
| sync_in | input | 1 | Sync pulse from the master timer, reloads phase 0 |
| trip_clr | input | 1 | Clears the latched trip |
| pwm_a | output | 1 | Drive output A |
| pwm_b | output | 1 | Drive output B |
| tb_count | output | CW | Present time-base count |

## Verification
An output action caused by a counter value k shows on pwm_a or pwm_b one clock after tb_count shows k. A comparator or sync input held during the cycle where the counter shows k is sampled at the following edge, so tb_count reads 0 at the next falling edge. A shadow value written in mid-cycle first shapes the pulses of the cycle that follows the next restart. Every expected item is tagged with a cycle index counted from reset release and compared at the falling clock edge of exactly that cycle. The stimulus is placed so that blanking boundaries, a trip with A high, a trip with B high, a trip while latched and a sync each land on a known counter value.

// File: rtl/pcm_leg_pkg.sv
package pcm_leg_pkg;

    localparam int NUM_CMP = 2;
    localparam int CMP_A   = 0;
    localparam int CMP_B   = 1;

    typedef enum logic [1:0] {
        BL_DELAY = 2'd0,
        BL_MASK  = 2'd1,
        BL_OPEN  = 2'd2
    } blank_st_e;

    typedef enum logic {
        TR_ARMED   = 1'b0,
        TR_LATCHED = 1'b1
    } trip_st_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } act_e;

    // Boundary (zero / period) beats the clearing match, which beats the setting match.
    function automatic act_e pick_action(input logic bound_ev, input logic clr_ev, input logic set_ev);
        if (bound_ev || clr_ev) return ACT_CLR;
        if (set_ev)             return ACT_SET;
        return ACT_HOLD;
    endfunction

    function automatic logic apply_action(input act_e act, input logic cur);
        unique case (act)
            ACT_SET:  return 1'b1;
            ACT_CLR:  return 1'b0;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pcm_timebase.sv
module pcm_timebase
    import pcm_leg_pkg::*;
#(
    parameter int CW      = 16,
    parameter int PRD_RST = 100,
    parameter int CA_RST  = 110,
    parameter int CB_RST  = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CW-1:0]                 prd_sh,
    input  logic [NUM_CMP-1:0][CW-1:0]    cmp_sh,
    input  logic                          sync_i,
    output logic [CW-1:0]                 cnt_o,
    output logic                          ev_zero,
    output logic                          ev_prd,
    output logic [NUM_CMP-1:0]            ev_cmp,
    output logic                          zero_next
);

    localparam logic [CW-1:0] ONE   = CW'(1);
    localparam logic [CW-1:0] PRD_R = CW'(PRD_RST);

    logic [CW-1:0] cnt;
    logic [CW-1:0] prd_w;
    logic [CW-1:0] last_v;

    assign last_v    = prd_w - ONE;
    assign ev_zero   = (cnt == '0);
    assign ev_prd    = (cnt == last_v);
    assign zero_next = sync_i || (cnt >= last_v);
    assign cnt_o     = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            prd_w <= PRD_R;
        end else begin
            if (zero_next) begin
                cnt   <= '0;
                prd_w <= prd_sh;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    // One shadowed compare channel per generate slice.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam logic [CW-1:0] RST_V = (g == CMP_A) ? CW'(CA_RST) : CW'(CB_RST);
        logic [CW-1:0] work;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                work <= RST_V;
            end else if (zero_next) begin
                work <= cmp_sh[g];
            end
        end

        assign ev_cmp[g] = (cnt == work);
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < prd_w);

    // Covers both the filtered trip resync and the external sync (R10).
    assert_resync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (cnt == '0));

endmodule

// File: rtl/pcm_blank.sv
module pcm_blank
    import pcm_leg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_next,
    input  logic [CW-1:0] ofs_i,
    input  logic [CW-1:0] len_i,
    output logic          blank_o
);

    localparam logic [CW:0] INC = (CW+1)'(1);

    blank_st_e     st, st_n;
    logic [CW-1:0] e, e_n;
    logic [CW:0]   e_inc;

    assign e_inc = {1'b0, e} + INC;

    always_comb begin
        st_n = st;
        e_n  = e;
        if (zero_next) begin
            st_n = BL_DELAY;
            e_n  = '0;
        end else begin
            unique case (st)
                BL_DELAY: begin
                    if (e_inc >= {1'b0, ofs_i}) begin
                        st_n = (len_i == '0) ? BL_OPEN : BL_MASK;
                        e_n  = '0;
                    end else begin
                        e_n = e_inc[CW-1:0];
                    end
                end
                BL_MASK: begin
                    if (e_inc >= {1'b0, len_i}) begin
                        st_n = BL_OPEN;
                        e_n  = '0;
                    end else begin
                        e_n = e_inc[CW-1:0];
                    end
                end
                BL_OPEN: begin
                    st_n = BL_OPEN;
                end
                default: begin
                    st_n = BL_OPEN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= BL_DELAY;
            e  <= '0;
        end else begin
            st <= st_n;
            e  <= e_n;
        end
    end

    always_comb begin
        blank_o = (st == BL_MASK);
    end

    assert_mask_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BL_MASK) |-> (e < len_i));

endmodule

// File: rtl/pcm_action.sv
module pcm_action
    import pcm_leg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_zero,
    input  logic ev_prd,
    input  logic ev_ca,
    input  logic ev_cb,
    input  logic cmp_hi,
    input  logic blank,
    input  logic trip_clr,
    output logic trip_evt,
    output logic pwm_a,
    output logic pwm_b
);

    trip_st_e tst, tst_n;
    logic     bound;
    logic     a_n, b_n;

    assign bound    = ev_zero || ev_prd;
    assign trip_evt = cmp_hi && !blank && (tst == TR_ARMED);

    always_comb begin
        tst_n = tst;
        unique case (tst)
            TR_ARMED:   if (trip_evt) tst_n = TR_LATCHED;
            TR_LATCHED: if (trip_clr) tst_n = TR_ARMED;
            default:    tst_n = TR_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tst <= TR_ARMED;
        else        tst <= tst_n;
    end

    always_comb begin
        a_n = apply_action(pick_action(bound, ev_cb, ev_ca), pwm_a);
        b_n = apply_action(pick_action(bound, ev_ca, ev_cb), pwm_b);
        if (trip_evt || (tst == TR_LATCHED)) b_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_a <= 1'b0;
            pwm_b <= 1'b0;
        end else begin
            pwm_a <= a_n;
            pwm_b <= b_n;
        end
    end

    assert_a_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bound |=> !pwm_a);

    assert_b_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bound |=> !pwm_b);

    assert_a_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_evt && !bound && !ev_ca && !ev_cb) |=> (pwm_a == $past(pwm_a)));

    assert_latched_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tst == TR_LATCHED) |-> !pwm_b);

endmodule

// File: rtl/pcm_leg.sv
module pcm_leg
    import pcm_leg_pkg::*;
#(
    parameter int CW      = 16,
    parameter int PRD_RST = 100,
    parameter int CB_RST  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] prd_shadow,
    input  logic [CW-1:0] cmpa_shadow,
    input  logic [CW-1:0] cmpb_shadow,
    input  logic [CW-1:0] blank_ofs,
    input  logic [CW-1:0] blank_len,
    input  logic          cmp_hi,
    input  logic          sync_in,
    input  logic          trip_clr,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic [CW-1:0] tb_count
);

    localparam int CA_RST = PRD_RST + 10;

    logic [NUM_CMP-1:0][CW-1:0] cmp_pack;
    logic [NUM_CMP-1:0]         ev_cmp;
    logic                       ev_zero;
    logic                       ev_prd;
    logic                       zero_next;
    logic                       blank;
    logic                       trip_evt;
    logic                       sync_any;

    assign cmp_pack[CMP_A] = cmpa_shadow;
    assign cmp_pack[CMP_B] = cmpb_shadow;
    assign sync_any        = sync_in || trip_evt;

    pcm_timebase #(
        .CW      (CW),
        .PRD_RST (PRD_RST),
        .CA_RST  (CA_RST),
        .CB_RST  (CB_RST)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prd_sh    (prd_shadow),
        .cmp_sh    (cmp_pack),
        .sync_i    (sync_any),
        .cnt_o     (tb_count),
        .ev_zero   (ev_zero),
        .ev_prd    (ev_prd),
        .ev_cmp    (ev_cmp),
        .zero_next (zero_next)
    );

    pcm_blank #(
        .CW (CW)
    ) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_next (zero_next),
        .ofs_i     (blank_ofs),
        .len_i     (blank_len),
        .blank_o   (blank)
    );

    pcm_action u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_zero  (ev_zero),
        .ev_prd   (ev_prd),
        .ev_ca    (ev_cmp[CMP_A]),
        .ev_cb    (ev_cmp[CMP_B]),
        .cmp_hi   (cmp_hi),
        .blank    (blank),
        .trip_clr (trip_clr),
        .trip_evt (trip_evt),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b)
    );

endmodule

// File: tb/pcm_leg_test.sv
`timescale 1ns/100ps
module pcm_leg_test;

    localparam int  CW      = 16;
    localparam real HALF    = 2.5;
    localparam int  END_CYC = 415;

    typedef struct {
        int    cyc;
        int    a;
        int    b;
        int    cnt;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] prd_shadow, cmpa_shadow, cmpb_shadow, blank_ofs, blank_len;
    logic          cmp_hi, sync_in, trip_clr;
    logic          pwm_a, pwm_b;
    logic [CW-1:0] tb_count;

    int   checks = 0;
    int   errors = 0;
    int   cyc    = 0;
    bit   run    = 1'b0;
    exp_t exp_q[$];

    always #(HALF) clk = ~clk;

    pcm_leg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .prd_shadow  (prd_shadow),
        .cmpa_shadow (cmpa_shadow),
        .cmpb_shadow (cmpb_shadow),
        .blank_ofs   (blank_ofs),
        .blank_len   (blank_len),
        .cmp_hi      (cmp_hi),
        .sync_in     (sync_in),
        .trip_clr    (trip_clr),
        .pwm_a       (pwm_a),
        .pwm_b       (pwm_b),
        .tb_count    (tb_count)
    );

    task automatic expect_at(input int c, input int a, input int b, input int n, input string tag);
        exp_t it;
        it.cyc = c; it.a = a; it.b = b; it.cnt = n; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic compare_item(input exp_t it);
        checks++;
        if (int'(pwm_a) != it.a || int'(pwm_b) != it.b || int'(tb_count) != it.cnt) begin
            errors++;
            $display("FAIL %s cyc %0d: a=%0d b=%0d cnt=%0d expected a=%0d b=%0d cnt=%0d",
                     it.tag, cyc, pwm_a, pwm_b, tb_count, it.a, it.b, it.cnt);
        end
    endtask

    // Monitor: one cycle index per falling edge after reset release.
    always @(negedge clk) begin
        if (run) begin
            cyc = cyc + 1;
            while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
                exp_t it;
                it = exp_q.pop_front();
                if (it.cyc < cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL %s item for cyc %0d missed, actual cyc %0d expected %0d", it.tag, it.cyc, cyc, it.cyc);
                end else begin
                    compare_item(it);
                end
            end
        end
    end

    task automatic drive_at(input int c);
        wait (cyc >= c);
        #1;
    endtask

    task automatic load_expects();
        // R1: defaults rule the first cycle (period 100, compare A unreachable, compare B 20)
        expect_at(20,  0, 0, 20, "R5");
        expect_at(21,  0, 1, 21, "R1");
        expect_at(50,  0, 1, 50, "R1");
        expect_at(99,  0, 1, 99, "R2");
        expect_at(100, 0, 0, 0,  "R2");
        // shadows (40, 10, 25) in effect
        expect_at(110, 0, 0, 10, "R4");
        expect_at(111, 1, 0, 11, "R4");
        expect_at(125, 1, 0, 25, "R4");
        expect_at(126, 0, 1, 26, "R5");
        expect_at(139, 0, 1, 39, "R2");
        expect_at(140, 0, 0, 0,  "R2");
        // compare B shadow changed to 30 mid-cycle: next cycle only
        expect_at(166, 1, 0, 26, "R3");
        expect_at(171, 0, 1, 31, "R3");
        expect_at(180, 0, 0, 0,  "R3");
        // blanked comparator pulses at counts 3 and 5
        expect_at(184, 0, 0, 4,  "R7");
        expect_at(186, 0, 0, 6,  "R7");
        expect_at(191, 1, 0, 11, "R7");
        // trip with A high at count 15
        expect_at(235, 1, 0, 15, "R8");
        expect_at(236, 1, 0, 0,  "R8");
        expect_at(237, 0, 0, 1,  "R8");
        // latched: comparator ignored, B never set
        expect_at(257, 1, 0, 21, "R9");
        expect_at(267, 0, 0, 31, "R9");
        expect_at(276, 0, 0, 0,  "R9");
        // cleared: B sets again, then trips at count 35
        expect_at(287, 1, 0, 11, "R4");
        expect_at(307, 0, 1, 31, "R9");
        expect_at(311, 0, 1, 35, "R8");
        expect_at(312, 0, 0, 0,  "R8");
        expect_at(313, 0, 0, 1,  "R8");
        // external sync at count 18
        expect_at(330, 1, 0, 18, "R10");
        expect_at(331, 1, 0, 0,  "R10");
        expect_at(332, 0, 0, 1,  "R10");
        expect_at(342, 1, 0, 11, "R10");
        expect_at(362, 0, 1, 31, "R10");
        expect_at(371, 0, 0, 0,  "R10");
        // compare A = 0 and compare B = period-1: boundary wins
        expect_at(372, 0, 0, 1,  "R6");
        expect_at(385, 0, 0, 14, "R6");
        expect_at(410, 0, 0, 39, "R6");
        expect_at(411, 0, 0, 0,  "R6");
    endtask

    initial begin
        rst_n       = 1'b0;
        prd_shadow  = 16'd40;
        cmpa_shadow = 16'd10;
        cmpb_shadow = 16'd25;
        blank_ofs   = 16'd2;
        blank_len   = 16'd4;
        cmp_hi      = 1'b0;
        sync_in     = 1'b0;
        trip_clr    = 1'b0;

        repeat (3) @(negedge clk);
        checks++;
        if (pwm_a !== 1'b0 || pwm_b !== 1'b0 || tb_count !== '0) begin
            errors++;
            $display("FAIL R1 reset: a=%0d b=%0d cnt=%0d expected a=0 b=0 cnt=0", pwm_a, pwm_b, tb_count);
        end
        load_expects();
        #1;
        rst_n = 1'b1;
        run   = 1'b1;

        fork
            begin
                drive_at(105); cmpb_shadow = 16'd30;
                drive_at(183); cmp_hi = 1'b1;
                drive_at(184); cmp_hi = 1'b0;
                drive_at(185); cmp_hi = 1'b1;
                drive_at(186); cmp_hi = 1'b0;
                drive_at(235); cmp_hi = 1'b1;
                drive_at(236); cmp_hi = 1'b0;
                drive_at(256); cmp_hi = 1'b1;
                drive_at(257); cmp_hi = 1'b0;
                drive_at(280); trip_clr = 1'b1;
                drive_at(281); trip_clr = 1'b0;
                drive_at(311); cmp_hi = 1'b1;
                drive_at(312); cmp_hi = 1'b0;
                drive_at(315); trip_clr = 1'b1;
                drive_at(316); trip_clr = 1'b0;
                drive_at(330); sync_in = 1'b1;
                drive_at(331); sync_in = 1'b0;
                drive_at(340); cmpa_shadow = 16'd0; cmpb_shadow = 16'd39;
                wait (cyc >= END_CYC);
            end
            begin
                #(2.0 * HALF * 20000.0);
                checks++;
                errors++;
                $display("FAIL watchdog: cyc %0d expected %0d", cyc, END_CYC);
            end
        join_any
        disable fork;

        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s item for cyc %0d never compared, actual cyc %0d expected %0d", it.tag, it.cyc, cyc, it.cyc);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule